// File: doc/BRIEF.md
# Disc Sector Position Tracker

This block follows the angular position of a spinning disc. It takes sector and index strobes that have already been separated from the transducer stream. It keeps a sector number that runs modulo a parameterised sector count, 24 by default. An index strobe forces the sector number back to zero and marks the tracker as synchronised. Sector strobes that arrive before the first index leave the sector number untouched.

A requested sector address is loaded with a load strobe, but only when the address names an existing sector. Its top bit is kept in a flop of its own, and the lower bits are kept in a separate register. A match flag is raised while the tracker is synchronised and the current sector equals the held address.

Every sector strobe also fires a retriggerable one-shot. Its width is set by a clock-frequency parameter and a width in microseconds. A speed monitor counts clock cycles between sector strobes and derives two flags. One says the disc is up to speed, meaning above 80 percent of nominal. The other says the disc has slowed or stopped.

Top module: `sector_tracker`

## Requirements
- R1: After reset, sector_num is 0 and synced, sector_match, sector_pulse, speed_up and speed_down are all 0.
- R2: An index strobe sets sector_num to 0 and synced to 1 on the next cycle. This holds even when a sector strobe is asserted in the same cycle, because the index strobe has priority.
- R3: While synced is 0, sector strobes leave sector_num at 0.
- R4: While synced is 1, each sector strobe advances sector_num by one on the next cycle, and the value SECTORS-1 (23) wraps to 0. Without either strobe, sector_num holds.
- R5: A load strobe with sec_addr at most SECTORS-1 replaces the requested sector from the next cycle onward.
- R6: A load strobe with sec_addr of SECTORS or above (24 to 31) is ignored. The previously held address stays in force, and such a value never produces a match.
- R7: sector_match is 1 exactly when synced is 1 and sector_num equals the held address. It changes in the same cycle as sector_num.
- R8: A sector strobe drives sector_pulse high from the next cycle for exactly CLK_MHZ*PULSE_US cycles. A strobe that arrives while the pulse is high restarts the full width.
- R9: A sector strobe sets speed_up to 1 if an earlier strobe has been seen since reset and the interval since that strobe is at most NOM_PERIOD_CYC*5/4 cycles. Otherwise the strobe sets speed_up to 0. speed_up also falls to 0 one cycle after the running interval exceeds that limit.
- R10: speed_down is 1 while the cycles since the last sector strobe (or since reset) reach NOM_PERIOD_CYC*SLOW_MULT. It is 0 on the cycle after a sector strobe. speed_up and speed_down are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_strobe | input | 1 | One-cycle sector strobe |
| idx_strobe | input | 1 | One-cycle index strobe |
| sec_addr | input | AW (5) | Requested sector address |
| addr_load | input | 1 | Loads sec_addr when it is a legal sector |
| sector_num | output | AW (5) | Current sector number |
| synced | output | 1 | An index strobe has been seen since reset |
| sector_match | output | 1 | Current sector equals the requested sector |
| sector_pulse | output | 1 | Fixed-width pulse after each sector strobe |
| speed_up | output | 1 | Disc above 80 percent of nominal speed |
| speed_down | output | 1 | Disc slowed or stopped |

## Verification
Timing is counted from the clock edge that samples a strobe:
- sector_num, synced and speed_up change at that edge.
- sector_match follows sector_num within the same cycle.
- sector_pulse rises at that edge and falls CLK_MHZ*PULSE_US edges later.
- speed_down rises exactly NOM_PERIOD_CYC*SLOW_MULT-1 edges after the last strobe.

The bench drives inputs on the falling edge and samples one falling edge after the sampling rising edge. Interval and width checks step one cycle at a time and test the last cycle before each boundary and the first cycle after it. The sweep covers every legal requested address over a full revolution, and also every illegal address.

// File: rtl/sector_pkg.sv
// Shared types and helpers for the sector tracker.
// Assumes: integer parameters are small enough for 32-bit arithmetic.
package sector_pkg;

    // Speed status pair
    typedef struct packed {
        logic up;
        logic down;
    } speed_t;

    // Longest sector interval, in cycles, that still counts as above 80 percent speed
    function automatic int up_limit(input int nom_period);
        return (nom_period * 5) / 4;
    endfunction

endpackage

// File: rtl/sector_counter.sv
// Modulo-SECTORS sector counter, resynchronised by the index strobe.
// Assumes: strobes are one clock wide; the index has priority over a sector strobe.
module sector_counter #(
    parameter int SECTORS = 24,
    parameter int AW      = $clog2(SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_strobe,
    input  logic          idx_strobe,
    output logic [AW-1:0] count,
    output logic          synced
);
    localparam logic [AW-1:0] LAST = AW'(SECTORS - 1);

    // Clear on index, advance on sector strobes once synchronised
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            synced <= 1'b0;
        end else if (idx_strobe) begin
            count  <= '0;
            synced <= 1'b1;
        end else if (sec_strobe && synced) begin
            count  <= (count == LAST) ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/addr_latch.sv
// Holds the requested sector: top bit in its own flop, lower bits in a register.
// Assumes: AW >= 2; out-of-range addresses are rejected at load time.
module addr_latch #(
    parameter int SECTORS = 24,
    parameter int AW      = $clog2(SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] req_addr
);
    localparam logic [AW-1:0] LAST = AW'(SECTORS - 1);

    logic          hi_q;
    logic [AW-2:0] lo_q;
    logic          legal;

    // Address is legal only when it names an existing sector
    always_comb legal = (addr_in <= LAST);

    // Top bit register
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_q <= 1'b0;
        else if (load && legal)  hi_q <= addr_in[AW-1];
    end

    // Lower bits register
    always_ff @(posedge clk) begin
        if (!rst_n)              lo_q <= '0;
        else if (load && legal)  lo_q <= addr_in[AW-2:0];
    end

    // Reassemble the held address
    always_comb req_addr = {hi_q, lo_q};
endmodule

// File: rtl/pulse_stretch.sv
// Retriggerable one-shot: output high for WIDTH cycles after each trigger.
// Assumes: WIDTH >= 1.
module pulse_stretch #(
    parameter int WIDTH = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(WIDTH + 1);

    logic [PW-1:0] remain_q;

    // Reload on trigger, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              remain_q <= '0;
        else if (trig)           remain_q <= PW'(WIDTH);
        else if (remain_q != '0) remain_q <= remain_q - 1'b1;
    end

    // High while cycles remain
    always_comb pulse = (remain_q != '0);
endmodule

// File: rtl/speed_sense.sv
// Measures cycles between sector strobes and flags up-to-speed and slowed states.
// Assumes: DOWN_LIM > UP_LIM + 1, so that the two flags never overlap.
module speed_sense
    import sector_pkg::*;
#(
    parameter int UP_LIM   = 125,
    parameter int DOWN_LIM = 400
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sec_strobe,
    output speed_t status
);
    localparam int CW = $clog2(DOWN_LIM + 1);
    localparam logic [CW-1:0] UP_C   = CW'(UP_LIM);
    localparam logic [CW-1:0] DOWN_C = CW'(DOWN_LIM);

    logic [CW-1:0] gap_q;
    logic          have_ref_q;
    logic          up_q;

    // Interval counter: restarts on a strobe, saturates at the slow limit
    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= '0;
        else if (sec_strobe)    gap_q <= CW'(1);
        else if (gap_q != DOWN_C) gap_q <= gap_q + 1'b1;
    end

    // Remember that a reference strobe exists
    always_ff @(posedge clk) begin
        if (!rst_n)          have_ref_q <= 1'b0;
        else if (sec_strobe) have_ref_q <= 1'b1;
    end

    // Up-to-speed flag: judged on each strobe, dropped once the gap is too long
    always_ff @(posedge clk) begin
        if (!rst_n)             up_q <= 1'b0;
        else if (sec_strobe)    up_q <= have_ref_q && (gap_q <= UP_C);
        else if (gap_q > UP_C)  up_q <= 1'b0;
    end

    // Pack the status pair
    always_comb begin
        status.up   = up_q;
        status.down = (gap_q >= DOWN_C);
    end
endmodule

// File: rtl/sector_tracker.sv
// Top level: sector counting, requested-sector match, sector one-shot, speed flags.
// Assumes: sector and index strobes are already separated, synchronous and one cycle wide.
module sector_tracker
    import sector_pkg::*;
#(
    parameter int SECTORS        = 24,
    parameter int CLK_MHZ        = 125,
    parameter int PULSE_US       = 24,
    parameter int NOM_PERIOD_CYC = 86805,
    parameter int SLOW_MULT      = 4,
    localparam int AW            = $clog2(SECTORS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_strobe,
    input  logic          idx_strobe,
    input  logic [AW-1:0] sec_addr,
    input  logic          addr_load,
    output logic [AW-1:0] sector_num,
    output logic          synced,
    output logic          sector_match,
    output logic          sector_pulse,
    output logic          speed_up,
    output logic          speed_down
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int UP_LIM    = up_limit(NOM_PERIOD_CYC);
    localparam int DOWN_LIM  = NOM_PERIOD_CYC * SLOW_MULT;

    logic [AW-1:0] req_addr;
    speed_t        spd;

    sector_counter #(.SECTORS(SECTORS), .AW(AW)) u_count (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe),
        .idx_strobe(idx_strobe), .count(sector_num), .synced(synced)
    );

    addr_latch #(.SECTORS(SECTORS), .AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(addr_load),
        .addr_in(sec_addr), .req_addr(req_addr)
    );

    pulse_stretch #(.WIDTH(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .trig(sec_strobe), .pulse(sector_pulse)
    );

    speed_sense #(.UP_LIM(UP_LIM), .DOWN_LIM(DOWN_LIM)) u_speed (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .status(spd)
    );

    // Match only against a synchronised position
    always_comb sector_match = synced && (sector_num == req_addr);

    // Unpack speed flags
    always_comb begin
        speed_up   = spd.up;
        speed_down = spd.down;
    end
endmodule

// File: rtl/sector_tracker_chk.sv
// Assertion checker for sector_tracker, attached by bind.
// Assumes: the port names of the top module.
module sector_tracker_chk #(
    parameter int SECTORS = 24,
    parameter int AW      = $clog2(SECTORS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_strobe,
    input logic          idx_strobe,
    input logic [AW-1:0] sec_addr,
    input logic          addr_load,
    input logic [AW-1:0] sector_num,
    input logic          synced,
    input logic          sector_match,
    input logic          sector_pulse,
    input logic          speed_up,
    input logic          speed_down
);
    localparam logic [AW-1:0] LAST = AW'(SECTORS - 1);

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_num <= LAST);

    // R2
    idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_strobe |=> (sector_num == '0) && synced);

    // R3
    unsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!synced && !idx_strobe) |=> (!synced && sector_num == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_strobe && !idx_strobe && synced) |=>
        (sector_num == (($past(sector_num) == LAST) ? '0 : $past(sector_num) + 1'b1)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_strobe && !idx_strobe) |=> $stable(sector_num));

    // R6
    illegal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && sec_addr > LAST && !sec_strobe && !idx_strobe) |=> $stable(sector_match));

    // R7
    match_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_match |-> synced);

    // R8
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |=> sector_pulse);

    // R10
    down_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_strobe |=> !speed_down);

    // R10
    speed_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({speed_up, speed_down}));
endmodule

bind sector_tracker sector_tracker_chk #(.SECTORS(SECTORS), .AW(AW)) u_chk (.*);

// File: tb/sector_tracker_tb.sv
// Self-checking bench for sector_tracker with a small timing configuration.
module sector_tracker_tb;
    localparam int SECTORS   = 24;
    localparam int CLK_MHZ   = 2;
    localparam int PULSE_US  = 24;
    localparam int NOM       = 100;
    localparam int SLOW_MULT = 4;
    localparam int PW        = CLK_MHZ * PULSE_US;   // 48
    localparam int UPL       = (NOM * 5) / 4;        // 125
    localparam int DNL       = NOM * SLOW_MULT;      // 400

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_strobe = 1'b0;
    logic       idx_strobe = 1'b0;
    logic [4:0] sec_addr = '0;
    logic       addr_load = 1'b0;
    logic [4:0] sector_num;
    logic       synced, sector_match, sector_pulse, speed_up, speed_down;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sector_tracker #(
        .SECTORS(SECTORS), .CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US),
        .NOM_PERIOD_CYC(NOM), .SLOW_MULT(SLOW_MULT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .idx_strobe(idx_strobe),
        .sec_addr(sec_addr), .addr_load(addr_load), .sector_num(sector_num),
        .synced(synced), .sector_match(sector_match), .sector_pulse(sector_pulse),
        .speed_up(speed_up), .speed_down(speed_down)
    );

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    task automatic strobe(input logic s, input logic i);
        sec_strobe = s;
        idx_strobe = i;
        tick();
        sec_strobe = 1'b0;
        idx_strobe = 1'b0;
    endtask

    task automatic load(input int a);
        sec_addr  = 5'(a);
        addr_load = 1'b1;
        tick();
        addr_load = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick();
        do_reset();
        // R1 reset state
        check(int'(sector_num), 0, "R1 sector_num");
        check(int'(synced), 0, "R1 synced");
        check(int'(sector_match), 0, "R1 match");
        check(int'(sector_pulse), 0, "R1 pulse");
        check(int'(speed_up), 0, "R1 speed_up");
        check(int'(speed_down), 0, "R1 speed_down");

        // R3 strobes before sync; R9 first strobe has no reference
        strobe(1'b1, 1'b0);
        check(int'(speed_up), 0, "R9 no reference");
        for (int k = 0; k < 3; k++) begin
            idle(1);
            strobe(1'b1, 1'b0);
            check(int'(sector_num), 0, "R3 unsynced count");
            check(int'(synced), 0, "R3 unsynced flag");
            check(int'(sector_match), 0, "R3 no match unsynced");
        end

        // R9 speed_up over several intervals
        begin
            int periods [5] = '{100, 125, 126, 60, 100};
            for (int p = 0; p < 5; p++) begin
                idle(periods[p] - 1);
                strobe(1'b1, 1'b0);
                check(int'(speed_up), (periods[p] <= UPL) ? 1 : 0, "R9 interval");
                check(int'(speed_down), 0, "R10 normal speed");
            end
        end
        idle(UPL);
        check(int'(speed_up), 1, "R9 hold at limit");
        idle(1);
        check(int'(speed_up), 0, "R9 drop past limit");

        // R10 slow detection
        strobe(1'b1, 1'b0);
        idle(DNL - 2);
        check(int'(speed_down), 0, "R10 before limit");
        idle(1);
        check(int'(speed_down), 1, "R10 at limit");
        check(int'(speed_up), 0, "R10 exclusive");
        strobe(1'b1, 1'b0);
        check(int'(speed_down), 0, "R10 cleared by strobe");
        check(int'(speed_up), 0, "R9 long interval");

        // R8 one-shot width
        idle(60);
        strobe(1'b1, 1'b0);
        check(int'(sector_pulse), 1, "R8 start");
        for (int j = 1; j < PW; j++) begin
            tick();
            check(int'(sector_pulse), 1, "R8 high");
        end
        tick();
        check(int'(sector_pulse), 0, "R8 end");
        // R8 retrigger
        idle(10);
        strobe(1'b1, 1'b0);
        idle(20);
        strobe(1'b1, 1'b0);
        for (int j = 1; j < PW; j++) begin
            tick();
            check(int'(sector_pulse), 1, "R8 retrigger high");
        end
        tick();
        check(int'(sector_pulse), 0, "R8 retrigger end");

        // R2 R4 R5 R7 sweep every legal address over a full revolution
        for (int a = 0; a < SECTORS; a++) begin
            load(a);
            strobe(1'b0, 1'b1);
            check(int'(sector_num), 0, "R2 index clear");
            check(int'(synced), 1, "R2 synced");
            check(int'(sector_match), (a == 0) ? 1 : 0, "R5 R7 match at 0");
            for (int k = 1; k <= SECTORS; k++) begin
                strobe(1'b1, 1'b0);
                check(int'(sector_num), k % SECTORS, "R4 count");
                check(int'(sector_match), ((k % SECTORS) == a) ? 1 : 0, "R7 match");
                idle(1);
            end
        end

        // R6 illegal addresses are ignored
        load(5);
        strobe(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) strobe(1'b1, 1'b0);
        check(int'(sector_match), 1, "R5 match at 5");
        for (int bad = SECTORS; bad < 32; bad++) begin
            load(bad);
            check(int'(sector_match), 1, "R6 illegal load kept address");
        end
        strobe(1'b0, 1'b1);
        for (int k = 1; k <= SECTORS; k++) begin
            strobe(1'b1, 1'b0);
            check(int'(sector_match), ((k % SECTORS) == 5) ? 1 : 0, "R6 revolution");
        end

        // R2 index has priority over a simultaneous sector strobe
        for (int k = 0; k < 7; k++) strobe(1'b1, 1'b0);
        check(int'(sector_num), 7, "R4 before priority");
        strobe(1'b1, 1'b1);
        check(int'(sector_num), 0, "R2 priority");
        idle(2);
        check(int'(sector_num), 0, "R4 idle hold");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule